// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block computes and holds the six arithmetic status flags of an integer datapath: zero, carry, overflow, sign, auxiliary (nibble carry) and parity. Each cycle the execute stage presents an update strobe, an operation class, both operands, the datapath result and the operand size (8, 16 or 32 bits). The block derives new flag values from those inputs. It writes only the flags that the operation class is allowed to touch and holds the others until an affecting operation arrives.

Dedicated controls set, clear or invert the carry flag directly. A combinational condition output evaluates a 4-bit branch condition code against the held flags, so a branch unit can resolve the flag-based, unsigned and signed comparisons in the same cycle it presents the code. The arithmetic datapath, the decode and the program counter sit outside this block.

Top module: `status_flag_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, all six flag outputs read 0 until the first update.
- R2: With upd_i high, op_i = 1 (add) and op_i = 2 (subtract) write all six flags on the next rising clock edge.
- R3: op_i = 3 (increment, computed as a_i + b_i) and op_i = 4 (decrement, computed as a_i - b_i) write every flag except carry, which keeps its previous value.
- R4: With upd_i low, or with op_i = 0 (move/push/pop class) or 5 to 7, every flag keeps its value.
- R5: Zero is set exactly when res_i, truncated to the operand size, is all zeros.
- R6: Carry is the unsigned carry out of the operand's top bit on add, or the borrow on subtract. size_i encodes 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. For example, 0x12AE - 0x12AF at 16 bits sets carry.
- R7: Overflow is set when the signed result is out of range for the operand size. For example, 0x72 + 0x0E at 8 bits sets overflow and leaves carry clear.
- R8: Sign is a copy of the most significant bit of res_i at the operand size.
- R9: Auxiliary is the carry out of bit 3 on add, or the borrow out of bit 3 on subtract, for every operand size.
- R10: Parity is set when res_i[7:0] holds an even number of ones, for every operand size.
- R11: cf_set_i, cf_clr_i and cf_cmc_i force, clear or invert carry on the next edge, in that priority order. They override any carry update in the same cycle, while the other flags still update.
- R12: cond_o follows cond_i against the held flags. The codes are: 0 OF, 1 !OF, 2 CF, 3 !CF, 4 ZF, 5 !ZF, 6 CF|ZF, 7 !CF&!ZF, 8 SF, 9 !SF, 10 PF, 11 !PF, 12 SF!=OF, 13 SF==OF, 14 ZF|(SF!=OF), 15 !ZF&(SF==OF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Flag update strobe |
| op_i | input | 3 | Operation class |
| size_i | input | 2 | Operand size select |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| res_i | input | DATA_W | Datapath result |
| cf_set_i | input | 1 | Force carry to 1 |
| cf_clr_i | input | 1 | Force carry to 0 |
| cf_cmc_i | input | 1 | Invert carry |
| cond_i | input | 4 | Condition code to test |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| af_o | output | 1 | Auxiliary flag |
| pf_o | output | 1 | Parity flag |
| cond_o | output | 1 | Condition result |

## Verification
A corrupted flag register appears at the flag outputs one edge after the update that wrote it. It appears at once on cond_o for every code that reads that flag. A wrong write mask stays hidden until the next operation. That operation must be one that should have preserved the flag, such as an increment holding carry or a move holding everything. For this reason, every cycle compares all six flags and one randomly chosen condition code against a reference model. The size-dependent selection of carry, overflow, sign and zero is then exposed within a few hundred mixed-size operations.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam logic [2:0] OPC_HOLD = 3'd0;
  localparam logic [2:0] OPC_ADD  = 3'd1;
  localparam logic [2:0] OPC_SUB  = 3'd2;
  localparam logic [2:0] OPC_INC  = 3'd3;
  localparam logic [2:0] OPC_DEC  = 3'd4;

  localparam int NUM_SIZES = 3;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;

  localparam logic [3:0] CC_ABOVE = 4'd7;
endpackage

// File: rtl/sfu_calc.sv
module sfu_calc
  import sfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] res_i,
  output flags_t            nxt_o
);
  localparam int SEL_W = $clog2(NUM_SIZES);

  logic is_sub;
  logic [NUM_SIZES-1:0] zf_v, sf_v, cy_v, ov_v;
  logic [SEL_W-1:0] sel;
  logic [4:0] nib;

  assign is_sub = (op_i == OPC_SUB) || (op_i == OPC_DEC);
  assign sel    = (size_i == 2'd3) ? SEL_W'(2) : SEL_W'(size_i);

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_sz
    localparam int W = 8 << k;
    logic [W:0] ext;
    logic am, bm, rm;
    assign ext  = is_sub ? ({1'b0, a_i[W-1:0]} - {1'b0, b_i[W-1:0]})
                         : ({1'b0, a_i[W-1:0]} + {1'b0, b_i[W-1:0]});
    assign am   = a_i[W-1];
    assign bm   = b_i[W-1];
    assign rm   = res_i[W-1];
    assign zf_v[k] = ~|res_i[W-1:0];
    assign sf_v[k] = rm;
    assign cy_v[k] = ext[W];
    // signed range: operands' signs vs result sign
    assign ov_v[k] = is_sub ? ((am ^ bm) & (rm ^ am)) : (~(am ^ bm) & (rm ^ am));
  end

  assign nib = is_sub ? ({1'b0, a_i[3:0]} - {1'b0, b_i[3:0]})
                      : ({1'b0, a_i[3:0]} + {1'b0, b_i[3:0]});

  always_comb begin
    nxt_o.zf = zf_v[sel];
    nxt_o.sf = sf_v[sel];
    nxt_o.cf = cy_v[sel];
    nxt_o.of = ov_v[sel];
    nxt_o.af = nib[4];
    nxt_o.pf = ~^res_i[7:0];
  end
endmodule

// File: rtl/sfu_state.sv
module sfu_state
  import sfu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic [2:0] op_i,
  input  flags_t     nxt_i,
  input  logic       cf_set_i,
  input  logic       cf_clr_i,
  input  logic       cf_cmc_i,
  output flags_t     q_o
);
  logic wr_all, wr_nocf, cf_ctl;
  flags_t d;

  assign wr_all  = upd_i && ((op_i == OPC_ADD) || (op_i == OPC_SUB));
  assign wr_nocf = upd_i && ((op_i == OPC_INC) || (op_i == OPC_DEC));
  assign cf_ctl  = cf_set_i | cf_clr_i | cf_cmc_i;

  always_comb begin
    d = q_o;
    if (wr_all || wr_nocf) begin
      d.zf = nxt_i.zf;
      d.sf = nxt_i.sf;
      d.of = nxt_i.of;
      d.af = nxt_i.af;
      d.pf = nxt_i.pf;
    end
    if (wr_all) d.cf = nxt_i.cf;
    // direct carry control outranks any update
    if (cf_set_i)      d.cf = 1'b1;
    else if (cf_clr_i) d.cf = 1'b0;
    else if (cf_cmc_i) d.cf = ~q_o.cf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_all && !wr_nocf && !cf_ctl) |=> (q_o == $past(q_o)));

  p_incdec_keeps_cf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_nocf && !cf_ctl) |=> (q_o.cf == $past(q_o.cf)));

  p_cf_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cf_set_i |=> q_o.cf);

  p_cf_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_clr_i && !cf_set_i) |=> !q_o.cf);

  p_cf_cmc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cf_cmc_i && !cf_set_i && !cf_clr_i) |=> (q_o.cf != $past(q_o.cf)));
endmodule

// File: rtl/sfu_cond.sv
module sfu_cond
  import sfu_pkg::*;
(
  input  flags_t     fl_i,
  input  logic [3:0] cond_i,
  output logic       true_o
);
  logic lt;
  assign lt = fl_i.sf ^ fl_i.of;

  always_comb begin
    unique case (cond_i[3:1])
      3'd0: true_o = fl_i.of;
      3'd1: true_o = fl_i.cf;
      3'd2: true_o = fl_i.zf;
      3'd3: true_o = fl_i.cf | fl_i.zf;
      3'd4: true_o = fl_i.sf;
      3'd5: true_o = fl_i.pf;
      3'd6: true_o = lt;
      default: true_o = fl_i.zf | lt;
    endcase
    // odd codes test the negation
    if (cond_i[0]) true_o = ~true_o;
  end

  always_comb begin
    if (cond_i == CC_ABOVE && true_o)
      p_above_r12: assert (!fl_i.cf && !fl_i.zf);
  end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cf_set_i,
  input  logic              cf_clr_i,
  input  logic              cf_cmc_i,
  input  logic [3:0]        cond_i,
  output logic              zf_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              sf_o,
  output logic              af_o,
  output logic              pf_o,
  output logic              cond_o
);
  flags_t nxt, q;

  sfu_calc #(.DATA_W(DATA_W)) u_calc (
    .op_i(op_i), .size_i(size_i), .a_i(a_i), .b_i(b_i), .res_i(res_i), .nxt_o(nxt)
  );

  sfu_state u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i), .op_i(op_i), .nxt_i(nxt),
    .cf_set_i(cf_set_i), .cf_clr_i(cf_clr_i), .cf_cmc_i(cf_cmc_i), .q_o(q)
  );

  sfu_cond u_cond (.fl_i(q), .cond_i(cond_i), .true_o(cond_o));

  assign zf_o = q.zf;
  assign cf_o = q.cf;
  assign of_o = q.of;
  assign sf_o = q.sf;
  assign af_o = q.af;
  assign pf_o = q.pf;

  initial p_width_ok: assert (DATA_W >= 32);

  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OPC_ADD && size_i == 2'd0) |=> (zf_o == ($past(res_i[7:0]) == 8'd0)));

  p_sign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OPC_SUB && size_i == 2'd1) |=> (sf_o == $past(res_i[15])));

  p_parity_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i == OPC_INC) |=> (pf_o == ($countones($past(res_i[7:0])) % 2 == 0)));
endmodule

// File: tb/status_flag_unit_tb.sv
`timescale 1ns/1ps
module status_flag_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] sz = '0;
  logic [31:0] a = '0, b = '0, r = '0;
  logic set = 1'b0, clr = 1'b0, cmc = 1'b0;
  logic [3:0] cc = '0;
  logic zf, cf, of, sf, af, pf, ct;
  int checks = 0, fails = 0;
  logic [5:0] exp_fl = '0; // {zf,cf,of,sf,af,pf}

  always #4 clk = ~clk;

  status_flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .op_i(op), .size_i(sz),
    .a_i(a), .b_i(b), .res_i(r), .cf_set_i(set), .cf_clr_i(clr), .cf_cmc_i(cmc),
    .cond_i(cc), .zf_o(zf), .cf_o(cf), .of_o(of), .sf_o(sf), .af_o(af), .pf_o(pf),
    .cond_o(ct)
  );

  function automatic logic [5:0] model(logic [5:0] cur, logic u, logic [2:0] o,
      logic [1:0] s, logic [31:0] x, logic [31:0] y, logic [31:0] rr,
      logic fs, logic fc, logic fm);
    int unsigned n;
    logic [63:0] m, xm, ym, rm;
    logic isadd, issub, z, c, v, sg, ax, p, sx, sy, sr;
    logic [5:0] nx;
    n  = 8 << ((s == 2'd3) ? 2 : s);
    m  = (64'd1 << n) - 64'd1;
    xm = {32'd0, x} & m; ym = {32'd0, y} & m; rm = {32'd0, rr} & m;
    isadd = u && (o == 3'd1 || o == 3'd3);
    issub = u && (o == 3'd2 || o == 3'd4);
    nx = cur;
    if (isadd || issub) begin
      sx = xm[n-1]; sy = ym[n-1]; sr = rm[n-1];
      z  = (rm == 64'd0);
      sg = sr;
      c  = isadd ? (((xm + ym) >> n) != 64'd0) : (xm < ym);
      v  = isadd ? (sx == sy && sr != sx) : (sx != sy && sr != sx);
      ax = isadd ? ((x[3:0] + y[3:0]) > 5'd15) : (x[3:0] < y[3:0]);
      p  = ($countones(rr[7:0]) % 2) == 0;
      if (o == 3'd3 || o == 3'd4) c = cur[4];
      nx = {z, c, v, sg, ax, p};
    end
    if (fs) nx[4] = 1'b1;
    else if (fc) nx[4] = 1'b0;
    else if (fm) nx[4] = ~cur[4];
    return nx;
  endfunction

  function automatic logic cmodel(logic [5:0] f, logic [3:0] c);
    logic z, k, v, s, p;
    {z, k, v, s, p} = {f[5], f[4], f[3], f[2], f[0]};
    case (c)
      4'd0: return v;        4'd1: return !v;
      4'd2: return k;        4'd3: return !k;
      4'd4: return z;        4'd5: return !z;
      4'd6: return k | z;    4'd7: return !k && !z;
      4'd8: return s;        4'd9: return !s;
      4'd10: return p;       4'd11: return !p;
      4'd12: return s != v;  4'd13: return s == v;
      4'd14: return z || (s != v);
      default: return !z && (s == v);
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] ex);
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, ex);
    end
  endtask

  // call at a negedge; returns at the next negedge with flags checked
  task automatic step(logic u, logic [2:0] o, logic [1:0] s, logic [31:0] x,
      logic [31:0] y, logic [31:0] rr, logic fs, logic fc, logic fm, logic [3:0] c,
      string tag);
    upd = u; op = o; sz = s; a = x; b = y; r = rr; set = fs; clr = fc; cmc = fm; cc = c;
    #1;
    chk("R12 condition", {31'd0, ct}, {31'd0, cmodel(exp_fl, c)});
    exp_fl = model(exp_fl, u, o, s, x, y, rr, fs, fc, fm);
    @(negedge clk);
    chk(tag, {26'd0, zf, cf, of, sf, af, pf}, {26'd0, exp_fl});
  endtask

  function automatic logic [31:0] calc_res(logic [2:0] o, logic [31:0] x, logic [31:0] y);
    case (o)
      3'd1, 3'd3: return x + y;
      3'd2, 3'd4: return x - y;
      default: return $urandom;
    endcase
  endfunction

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    #3;
    chk("R1 reset", {26'd0, zf, cf, of, sf, af, pf}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {26'd0, zf, cf, of, sf, af, pf}, 32'd0);

    // R7: signed overflow without carry
    step(1, 3'd1, 2'd0, 32'h72, 32'h0E, 32'h80, 0, 0, 0, 4'd0, "R7 flags");
    chk("R7 of", {31'd0, of}, 32'd1);
    chk("R7 cf", {31'd0, cf}, 32'd0);
    // R6: 16-bit borrow
    step(1, 3'd2, 2'd1, 32'h12AE, 32'h12AF, 32'hFFFF_FFFF, 0, 0, 0, 4'd2, "R6 flags");
    chk("R6 cf", {31'd0, cf}, 32'd1);
    chk("R8 sf", {31'd0, sf}, 32'd1);
    // R5 / R9: wrap to zero with nibble carry
    step(1, 3'd1, 2'd0, 32'h0F, 32'hF1, 32'h100, 0, 0, 0, 4'd4, "R5 flags");
    chk("R5 zf", {31'd0, zf}, 32'd1);
    chk("R9 af", {31'd0, af}, 32'd1);
    // R3: increment keeps carry (carry currently 1)
    step(1, 3'd3, 2'd0, 32'hFF, 32'h1, 32'h100, 0, 1, 0, 4'd6, "R11 clr");
    step(1, 3'd3, 2'd0, 32'h7F, 32'h1, 32'h80, 0, 0, 0, 4'd3, "R3 flags");
    chk("R3 cf held", {31'd0, cf}, 32'd0);
    step(0, 3'd0, 2'd0, 0, 0, 0, 1, 0, 0, 4'd12, "R11 set");
    step(1, 3'd4, 2'd0, 32'h00, 32'h1, 32'hFFFF_FFFF, 0, 0, 0, 4'd8, "R3 dec");
    chk("R3 cf held after dec", {31'd0, cf}, 32'd1);
    // R10: parity from low byte of 16-bit result
    step(1, 3'd1, 2'd1, 32'h0100, 32'h0053, 32'h0153, 0, 0, 0, 4'd10, "R10 flags");
    chk("R10 pf", {31'd0, pf}, 32'd1);
    // R4: move class and idle leave flags
    step(1, 3'd0, 2'd2, 32'h0, 32'h0, 32'h0, 0, 0, 0, 4'd5, "R4 move");
    step(1, 3'd6, 2'd2, 32'h5, 32'h5, 32'h0, 0, 0, 0, 4'd7, "R4 reserved");
    step(0, 3'd1, 2'd0, 32'h0F, 32'hF1, 32'h100, 0, 0, 0, 4'd13, "R4 idle");
    chk("R4 zf held", {31'd0, zf}, 32'd0);
    // R11: set beats clear and an update producing no carry
    step(1, 3'd1, 2'd2, 32'h1, 32'h1, 32'h2, 1, 1, 0, 4'd14, "R11 priority");
    chk("R11 cf forced", {31'd0, cf}, 32'd1);
    step(1, 3'd2, 2'd2, 32'h5, 32'h3, 32'h2, 0, 0, 1, 4'd15, "R11 cmc");
    chk("R11 cf inverted", {31'd0, cf}, 32'd0);
    // R8: 32-bit sign
    step(1, 3'd2, 2'd3, 32'd15, 32'd97, 32'd15 - 32'd97, 0, 0, 0, 4'd9, "R8 flags");
    chk("R8 sf 32", {31'd0, sf}, 32'd1);

    // R2: mixed random traffic across all sizes and classes
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] o;
      logic [31:0] x, y;
      o = 3'($urandom_range(0, 7));
      x = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 300)) : $urandom;
      y = (o == 3'd3 || o == 3'd4) ? 32'd1 :
          (($urandom_range(0, 3) == 0) ? x : $urandom);
      step($urandom_range(0, 7) != 0, o, 2'($urandom_range(0, 3)), x, y, calc_res(o, x, y),
           $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 15) == 0, 4'($urandom_range(0, 15)),
           "R2 R5 R6 R7 R8 R9 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule